// File: doc/BRIEF.md
# Boxcar and N-Point Sample Integrator

This block integrates a stream of complex samples, each made of a signed I word and a signed Q word, in one of two modes. In sliding (boxcar) mode it produces one output for every accepted input. Each output is the sum of the most recent L samples, so the output rate equals the input rate. In block mode it adds L consecutive samples, emits their sum once, and then starts a fresh block, so the output rate falls by a factor of L. Both modes share a single adder datapath and a single length input.

Samples are accepted only during a run. A trigger pulse opens a run, and the run lasts for a programmed number of accepted samples. The sliding mode keeps a running sum. Each new sample is added to it, and the sample that leaves the window is subtracted. That outgoing sample is read from a circular history memory sized for the longest window. Sums carry enough extra bits for the longest window, so they never wrap.

Top module: `iq_window_integrator`

## Requirements
- R1: Samples are accepted only while `active` is high. A `trig` pulse while idle loads `run_len`, and `active` stays high until that many samples with `in_valid` high have been accepted. A trigger during a run has no effect. A trigger with `run_len` = 0 starts nothing. Before the first trigger no output is produced.
- R2: With `mode` = 0 (sliding), every accepted sample produces one output one clock later. The output is the sum of the last L accepted samples, or of all of them when fewer than L have been accepted.
- R3: In sliding mode `out_partial` is 1 exactly on the first L−1 outputs after a run start or a clear.
- R4: With `mode` = 1 (block), every L-th accepted sample produces one output one clock later. That output is the sum of those L samples, and `out_partial` is 0.
- R5: With L = 1, both modes output each sample sign-extended to the output width, one clock later.
- R6: The effective length L is `len`, except that `len` = 0 acts as 1 and any `len` above LMAX (256) acts as LMAX.
- R7: A change of `mode` or of the effective length clears the running sum, the history pointer and the block count. A sample accepted in the same cycle becomes the first sample under the new setting.
- R8: Outputs are DW+log2(LMAX) = 40 bits wide. A full window of the most negative or the most positive 32-bit sample gives the exact sum.
- R9: `out_valid` is a one-cycle strobe that only follows an accepted sample. After reset `out_valid`, `out_i`, `out_q`, `out_partial` and `active` are 0.
- R10: Every new run starts from a cleared sum, pointer and count. No sample from an earlier run enters its outputs.
- R11: Cycles with `in_valid` low inside a run do not change the sums or the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW (32) | In-phase sample, two's complement |
| in_q | input | DW (32) | Quadrature sample, two's complement |
| trig | input | 1 | Run start pulse |
| mode | input | 1 | 0 = sliding window, 1 = block sum |
| len | input | log2(LMAX)+1 (9) | Window or block length |
| run_len | input | RW (24) | Number of samples accepted per run |
| active | output | 1 | High while a run is accepting samples |
| out_valid | output | 1 | Output strobe |
| out_i | output | DW+log2(LMAX) (40) | In-phase sum |
| out_q | output | DW+log2(LMAX) (40) | Quadrature sum |
| out_partial | output | 1 | Sliding output covers fewer than L samples |

## Verification
The main function is driven with several patterns, and each one exposes a different class of fault:
- A linear ramp makes a wrong window edge, such as an off-by-one in the outgoing sample, show up as a constant offset.
- A hashed pseudo-random stream catches a reused or stale history entry.
- Alternating near-full-scale values catch sign-extension faults.
- A constant most-negative I word with a most-positive Q word, over a 256-sample window, checks that the sums do not overflow.

Runs with idle gaps, a mid-run trigger, and mid-run changes of length and of mode separate correct gating and clearing from state that leaks. A repeated run shows whether history from the previous run is still being used.

// File: rtl/iq_window_integrator.sv
module iq_window_integrator #(
  parameter int DW   = 32,
  parameter int LMAX = 256,
  parameter int RW   = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [DW-1:0]                 in_i,
  input  logic [DW-1:0]                 in_q,
  input  logic                          trig,
  input  logic                          mode,
  input  logic [$clog2(LMAX):0]         len,
  input  logic [RW-1:0]                 run_len,
  output logic                          active,
  output logic                          out_valid,
  output logic [DW+$clog2(LMAX)-1:0]    out_i,
  output logic [DW+$clog2(LMAX)-1:0]    out_q,
  output logic                          out_partial
);
  localparam int PW = $clog2(LMAX);
  localparam int LW = PW + 1;
  localparam int AW = DW + PW;

  logic [LW-1:0] leff, leff_q, fill, fill_b, bcnt, bcnt_b;
  logic          mode_q, chg, start, take, last;
  logic [RW-1:0] rem;
  logic [PW-1:0] ptr, ptr_b, old_addr;
  logic [AW-1:0] sum_i, sum_q, acc_i, acc_q;
  logic [AW-1:0] sum_bi, sum_bq, acc_bi, acc_bq;
  logic [AW-1:0] x_i, x_q, old_i, old_q, box_i, box_q, blk_i, blk_q;
  logic [DW-1:0] hist_i [LMAX];
  logic [DW-1:0] hist_q [LMAX];

  assign leff   = (len == '0) ? LW'(1) : (len > LW'(LMAX)) ? LW'(LMAX) : len;
  assign chg    = (mode != mode_q) || (leff != leff_q);
  assign active = (rem != '0);
  assign start  = trig && !active && (run_len != '0);
  assign take   = active && in_valid;

  assign ptr_b  = chg ? '0 : ptr;
  assign fill_b = chg ? '0 : fill;
  assign bcnt_b = chg ? '0 : bcnt;
  assign sum_bi = chg ? '0 : sum_i;
  assign sum_bq = chg ? '0 : sum_q;
  assign acc_bi = chg ? '0 : acc_i;
  assign acc_bq = chg ? '0 : acc_q;

  assign x_i      = {{PW{in_i[DW-1]}}, in_i};
  assign x_q      = {{PW{in_q[DW-1]}}, in_q};
  assign old_addr = ptr_b - leff[PW-1:0];
  assign old_i    = (fill_b >= leff) ? {{PW{hist_i[old_addr][DW-1]}}, hist_i[old_addr]} : '0;
  assign old_q    = (fill_b >= leff) ? {{PW{hist_q[old_addr][DW-1]}}, hist_q[old_addr]} : '0;
  assign box_i    = sum_bi + x_i - old_i;
  assign box_q    = sum_bq + x_q - old_q;
  assign blk_i    = acc_bi + x_i;
  assign blk_q    = acc_bq + x_q;
  assign last     = (bcnt_b == leff - LW'(1));

  always_ff @(posedge clk) begin
    if (take && !mode) begin
      hist_i[ptr_b] <= in_i;
      hist_q[ptr_b] <= in_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;  leff_q <= '0;   rem <= '0;
      ptr <= '0;  fill <= '0;  bcnt <= '0;
      sum_i <= '0;  sum_q <= '0;  acc_i <= '0;  acc_q <= '0;
      out_valid <= 1'b0;  out_partial <= 1'b0;
      out_i <= '0;  out_q <= '0;
    end else begin
      mode_q    <= mode;
      leff_q    <= leff;
      out_valid <= 1'b0;
      if (start) begin
        rem <= run_len;
        ptr <= '0;  fill <= '0;  bcnt <= '0;
        sum_i <= '0;  sum_q <= '0;  acc_i <= '0;  acc_q <= '0;
      end else if (take) begin
        rem <= rem - RW'(1);
        if (!mode) begin
          ptr         <= ptr_b + PW'(1);
          fill        <= (fill_b >= leff) ? fill_b : fill_b + LW'(1);
          sum_i       <= box_i;
          sum_q       <= box_q;
          bcnt        <= '0;
          acc_i       <= '0;
          acc_q       <= '0;
          out_i       <= box_i;
          out_q       <= box_q;
          out_valid   <= 1'b1;
          out_partial <= (fill_b + LW'(1)) < leff;
        end else begin
          ptr   <= '0;  fill <= '0;  sum_i <= '0;  sum_q <= '0;
          if (last) begin
            bcnt        <= '0;
            acc_i       <= '0;
            acc_q       <= '0;
            out_i       <= blk_i;
            out_q       <= blk_q;
            out_valid   <= 1'b1;
            out_partial <= 1'b0;
          end else begin
            bcnt  <= bcnt_b + LW'(1);
            acc_i <= blk_i;
            acc_q <= blk_q;
          end
        end
      end else if (chg) begin
        ptr <= '0;  fill <= '0;  bcnt <= '0;
        sum_i <= '0;  sum_q <= '0;  acc_i <= '0;  acc_q <= '0;
      end
    end
  end

  a_r9_valid_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && active));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !out_valid);
  a_r1_run_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (active && in_valid) |=> (rem == $past(rem) - RW'(1)));
  a_r4_block_not_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode)) |-> !out_partial);
  a_r5_unit_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(leff == LW'(1))) |->
      (out_i == AW'($signed($past(in_i))) && out_q == AW'($signed($past(in_q)))));
  a_r11_idle_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !in_valid) |=> (rem == $past(rem)));
endmodule

// File: tb/tb_iq_window_integrator.sv
module tb_iq_window_integrator;
  localparam int DW = 32, LMAX = 256, RW = 24, PW = 8, AW = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, trig = 1'b0, mode = 1'b0;
  logic [DW-1:0] in_i = '0, in_q = '0;
  logic [PW:0] len = '0;
  logic [RW-1:0] run_len = '0;
  logic active, out_valid, out_partial;
  logic [AW-1:0] out_i, out_q;

  iq_window_integrator #(.DW(DW), .LMAX(LMAX), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .trig(trig), .mode(mode), .len(len), .run_len(run_len), .active(active),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_partial(out_partial));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // columns: mode, len, run_len, pattern, samples, gaps, trig_at, chg_at, len2, mode2
  localparam int NV = 11;
  localparam int V_MODE [NV] = '{0, 0, 1, 1, 0, 1, 0,   0,   1,  0,  0};
  localparam int V_LEN  [NV] = '{4, 5, 3, 7, 1, 1, 0, 300, 256,  4,  4};
  localparam int V_RUN  [NV] = '{20,30,12,28,10,10, 8, 300, 512, 10, 10};
  localparam int V_PAT  [NV] = '{0, 3, 0, 3, 1, 3, 3,   2,   2,  3,  3};
  localparam int V_NS   [NV] = '{20,30,12,28,10,10, 8, 300, 512, 15, 10};
  localparam int V_GAP  [NV] = '{0, 1, 0, 1, 0, 0, 0,   0,   0,  0,  0};
  localparam int V_TRG  [NV] = '{-1,10,-1,-1,-1,-1,-1, -1,  -1, -1, -1};
  localparam int V_CHG  [NV] = '{12,-1,-1, 9,-1,-1,-1, -1,  -1, -1, -1};
  localparam int V_LEN2 [NV] = '{2, 0, 0, 7, 0, 0, 0,   0,   0,  0,  0};
  localparam int V_MOD2 [NV] = '{0, 0, 0, 0, 0, 0, 0,   0,   0,  0,  0};

  function automatic string tag_of(int v);
    case (v)
      0: return "R2/R3/R7";
      1: return "R2/R11/R1";
      2: return "R4";
      3: return "R4/R7";
      4, 5: return "R5";
      6: return "R6";
      7: return "R6/R8";
      8: return "R8";
      9: return "R1";
      default: return "R10";
    endcase
  endfunction

  function automatic int lclamp(int l);
    if (l == 0) return 1;
    if (l > LMAX) return LMAX;
    return l;
  endfunction

  function automatic logic [31:0] pv(int pat, int k, bit q);
    logic [31:0] kk;
    kk = 32'(k);
    case (pat)
      0: return q ? 32'(5) - kk * 32'd3 : kk * 32'd1000 - 32'd7;
      1: return q ? kk * 32'd77 : (kk[0] ? 32'h7fffffff : 32'h80000001);
      2: return q ? 32'h7fffffff : 32'h80000000;
      default: return q ? (kk + 32'd3) * 32'h85EBCA6B : ((kk + 32'd1) * 32'h9E3779B1) ^ (kk << 7);
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_out(string tag, bit ev, longint ei, longint eq, bit ep);
    if (!ev) check(out_valid == 1'b0, tag, "out_valid", longint'(out_valid), 0);
    else begin
      check(out_valid == 1'b1, tag, "out_valid", longint'(out_valid), 1);
      check(longint'($signed(out_i)) == ei, tag, "out_i", longint'($signed(out_i)), ei);
      check(longint'($signed(out_q)) == eq, tag, "out_q", longint'($signed(out_q)), eq);
      check(out_partial == ep, tag, "out_partial", longint'(out_partial), longint'(ep));
    end
  endtask

  longint mh_i [1024];
  longint mh_q [1024];

  task automatic run_vec(int v);
    string tag;
    int L, m, n, bc, acc_cnt;
    longint bi, bq, ei, eq;
    bit ev, ep;
    tag = tag_of(v);
    @(negedge clk);
    mode = V_MODE[v][0]; len = 9'(V_LEN[v]); run_len = RW'(V_RUN[v]);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    L = lclamp(V_LEN[v]); m = V_MODE[v]; n = 0; bc = 0; bi = 0; bq = 0; acc_cnt = 0;
    for (int k = 0; k < V_NS[v]; k++) begin
      if (V_GAP[v] != 0 && k % 3 == 2) begin
        in_valid = 1'b0;
        @(negedge clk);
        check_out(tag, 1'b0, 0, 0, 1'b0);
      end
      in_valid = 1'b1; in_i = pv(V_PAT[v], k, 1'b0); in_q = pv(V_PAT[v], k, 1'b1);
      if (k == V_TRG[v]) trig = 1'b1;
      if (k == V_CHG[v]) begin
        len = 9'(V_LEN2[v]); mode = V_MOD2[v][0];
        L = lclamp(V_LEN2[v]); m = V_MOD2[v]; n = 0; bc = 0; bi = 0; bq = 0;
      end
      ev = 1'b0; ep = 1'b0; ei = 0; eq = 0;
      if (acc_cnt < V_RUN[v]) begin
        acc_cnt++;
        mh_i[n] = longint'($signed(in_i)); mh_q[n] = longint'($signed(in_q));
        if (m == 0) begin
          for (int j = (n - L + 1 < 0 ? 0 : n - L + 1); j <= n; j++) begin
            ei += mh_i[j]; eq += mh_q[j];
          end
          ev = 1'b1; ep = (n + 1) < L;
        end else begin
          bi += mh_i[n]; bq += mh_q[n]; bc++;
          if (bc == L) begin ev = 1'b1; ei = bi; eq = bq; bi = 0; bq = 0; bc = 0; end
        end
        n++;
      end
      @(negedge clk);
      trig = 1'b0; in_valid = 1'b0;
      check_out(tag, ev, ei, eq, ep);
    end
    @(negedge clk);
    check(active == 1'b0, "R1", "active after run", longint'(active), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_partial == 1'b0, "R9", "reset strobes", longint'(out_valid), 0);
    check(out_i == '0 && out_q == '0, "R9", "reset sums", longint'(out_i), 0);
    check(active == 1'b0, "R9", "reset active", longint'(active), 0);

    mode = 1'b0; len = 9'd2; run_len = RW'(5);
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; in_i = 32'(k + 1); in_q = 32'(k);
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "output before trigger", longint'(out_valid), 0);
    end
    in_valid = 1'b0;

    run_len = '0; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    @(negedge clk);
    check(active == 1'b0, "R1", "zero-length run", longint'(active), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule